// File: doc/BRIEF.md
# Windowed Horizontal Sync Qualifier

This block watches a sampled composite sync input, which is active low, and decides whether each horizontal sync pulse is genuine. It has two modes, selected by `track_en`. In acquisition mode it waits for the synchronised input to go high. It then takes the next falling edge and pulses `line_restart` so that the external line timer can be zeroed. The pulse is accepted only if it stays low long enough to rule out half-line equalizing pulses. In tracking mode an external strobe, `win_open`, opens a search window of fixed length. Only a falling edge inside that window counts. The minimum width is shorter, so equalizing pulses still qualify.

At an accepted edge the block captures the low-order bits of the free-running line timer as a signed phase error sample. In tracking mode every window ends in exactly one verdict at a fixed cycle: either `pulse_valid` with the captured error, or `pulse_missed` with a zero error. The block counts consecutive misses and raises `resync_req` when the limit is reached, so that the surrounding loop can fall back to acquisition. The loop filter and the timer arithmetic live outside this block.

Top module: `sync_pulse_qualifier`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `line_restart`, `pulse_valid`, `pulse_missed` and `resync_req` are low and `phase_err` is zero.
- R2: The raw input passes through a two-stage synchroniser. In acquisition mode (`track_en`=0), once the synchronised input has been seen high, each falling edge of it produces a one-cycle `line_restart`, whether or not the pulse is later accepted.
- R3: In acquisition mode a pulse is accepted when the input stays low for at least ACQ_MIN consecutive samples (default 200). Acceptance gives a one-cycle `pulse_valid` ACQ_MIN-1 cycles after `line_restart`. `phase_err` then carries `line_phase` as it stood in the cycle the edge was detected, which is the cycle before `line_restart`.
- R4: In acquisition mode a pulse shorter than ACQ_MIN samples gives no `pulse_valid` and no `pulse_missed`, and the block waits for the next falling edge.
- R5: In acquisition mode there is no upper width limit. A low period of any length gives exactly one `pulse_valid`, and the input must go high again before another pulse can be taken.
- R6: In tracking mode (`track_en`=1) the window covers the 2*HALF_WIN cycles that start in the cycle after the edge that samples `win_open`. Only a synchronised falling edge detected in one of those cycles counts. An input that is already low when the window opens gives no edge.
- R7: In tracking mode an in-window edge is accepted when the input stays low for at least TRK_MIN consecutive samples (default 100), with no upper limit. A shorter pulse is reported as missed.
- R8: Each tracking window gives exactly one verdict, either `pulse_valid` or `pulse_missed`. It is asserted WIN_LEN+TRK_MIN cycles after the clock edge that sampled `win_open`, whatever the edge position.
- R9: With `pulse_missed`, `phase_err` is zero. With a tracking `pulse_valid`, `phase_err` is `line_phase` from the cycle in which the edge was detected.
- R10: `resync_req` pulses together with the MISS_LIMIT-th consecutive `pulse_missed` (default 32), after which the count starts again from zero. Any `pulse_valid` clears the count.
- R11: A `win_open` that arrives while a window is in progress, or before its verdict, is ignored.
- R12: `pulse_valid` and `pulse_missed` are one-cycle strobes and are never high together. `phase_err` is zero in every cycle with neither strobe.
- R13: Leaving tracking mode clears the miss count. No tracking verdict appears while in acquisition mode, and no `line_restart` appears while in tracking mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_n_raw | input | 1 | Composite sync sample, active low, asynchronous |
| track_en | input | 1 | 0 = acquisition mode, 1 = tracking mode |
| win_open | input | 1 | One-cycle strobe that opens a tracking window |
| line_phase | input | ERR_W | Low-order bits of the free-running line timer |
| line_restart | output | 1 | One-cycle request to zero the line timer (acquisition edge) |
| pulse_valid | output | 1 | One-cycle strobe: pulse accepted |
| pulse_missed | output | 1 | One-cycle strobe: tracking window ended with no good pulse |
| phase_err | output | ERR_W | Two's-complement phase error sample, non-zero only with pulse_valid |
| resync_req | output | 1 | One-cycle request to return to acquisition |

## Verification
A raw input change becomes visible to the edge detector two cycles after the edge that samples it. An edge whose first low sample is taken at clock k is therefore detected in cycle k+1, which makes `line_restart` rise at clock k+2 and an acquisition `pulse_valid` rise at clock k+ACQ_MIN+1. A tracking verdict rises exactly WIN_LEN+TRK_MIN clocks after `win_open` is sampled. The bench numbers its cycles from the falling edge at which it drives each stimulus and computes these due cycles, and the expected error value, from the offsets above. At every falling clock edge it compares all outputs, so a strobe that arrives one cycle early or late, or twice, is caught as well as a wrong value.

// File: rtl/sync_qual_pkg.sv
package sync_qual_pkg;

    // Synchronised view of the sync input handed to both engines
    typedef struct packed {
        logic level;   // synchronised input level (1 = no sync)
        logic fall;    // high-to-low transition seen this cycle
    } sync_view_t;

    typedef enum logic [1:0] {
        ACQ_ARM,       // waiting for input high
        ACQ_HUNT,      // armed, waiting for falling edge
        ACQ_MEASURE    // counting low time
    } acq_state_e;

    typedef enum logic [1:0] {
        TRK_IDLE,      // no window open
        TRK_SEEK,      // window running, no edge yet
        TRK_MEASURE,   // edge caught, counting low time
        TRK_HOLD       // decision made, waiting for report point
    } trk_state_e;

    // Bits needed to hold values 0..n
    function automatic int unsigned span_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/sq_sync2.sv
module sq_sync2
    import sync_qual_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       raw_n,
    output sync_view_t view
);
    logic meta_q, stable_q, prev_q;

    // Idle level of the line is high; resetting to 1 avoids a false edge
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= 1'b1;
            stable_q <= 1'b1;
            prev_q   <= 1'b1;
        end else begin
            meta_q   <= raw_n;
            stable_q <= meta_q;
            prev_q   <= stable_q;
        end
    end

    always_comb begin
        view.level = stable_q;
        view.fall  = prev_q & ~stable_q;
    end

endmodule

// File: rtl/sq_acq.sv
module sq_acq
    import sync_qual_pkg::*;
#(
    parameter int unsigned ACQ_MIN = 200,
    parameter int unsigned ERR_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  sync_view_t       view,
    input  logic [ERR_W-1:0] line_phase,
    output logic             restart,
    output logic             valid,
    output logic [ERR_W-1:0] err
);
    localparam int unsigned CW = span_bits(ACQ_MIN);
    localparam logic [CW-1:0] LAST_CNT = CW'(ACQ_MIN - 1);

    acq_state_e       state_q;
    logic [CW-1:0]    low_cnt_q;
    logic [ERR_W-1:0] cap_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q   <= ACQ_ARM;
            low_cnt_q <= '0;
            cap_q     <= '0;
            restart   <= 1'b0;
            valid     <= 1'b0;
            err       <= '0;
        end else begin
            restart <= 1'b0;
            valid   <= 1'b0;
            err     <= '0;
            case (state_q)
                ACQ_ARM: begin
                    if (view.level) state_q <= ACQ_HUNT;
                end
                ACQ_HUNT: begin
                    if (view.fall) begin
                        restart   <= 1'b1;
                        cap_q     <= line_phase;
                        low_cnt_q <= CW'(1);
                        state_q   <= ACQ_MEASURE;
                    end
                end
                ACQ_MEASURE: begin
                    if (view.level) begin
                        // too short: equalizing pulse or noise, hunt again
                        state_q <= ACQ_HUNT;
                    end else if (low_cnt_q == LAST_CNT) begin
                        valid   <= 1'b1;
                        err     <= cap_q;
                        state_q <= ACQ_ARM;   // must see high before next edge
                    end else begin
                        low_cnt_q <= low_cnt_q + CW'(1);
                    end
                end
                default: state_q <= ACQ_ARM;
            endcase
        end
    end

    logic lvl;
    assign lvl = view.level;

    assert_restart_single_R2: assert property (@(posedge clk) disable iff (rst)
        restart |=> !restart);

    assert_accept_after_low_R3: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(!lvl));

endmodule

// File: rtl/sq_track.sv
module sq_track
    import sync_qual_pkg::*;
#(
    parameter int unsigned TRK_MIN  = 100,
    parameter int unsigned HALF_WIN = 96,
    parameter int unsigned ERR_W    = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             win_open,
    input  sync_view_t       view,
    input  logic [ERR_W-1:0] line_phase,
    output logic             valid,
    output logic             missed,
    output logic [ERR_W-1:0] err
);
    localparam int unsigned WIN_LEN = 2 * HALF_WIN;
    localparam int unsigned RPT     = WIN_LEN + TRK_MIN - 1;
    localparam int unsigned WW      = span_bits(RPT);
    localparam int unsigned LW      = span_bits(TRK_MIN);
    localparam logic [WW-1:0] WIN_END = WW'(WIN_LEN);
    localparam logic [WW-1:0] RPT_C   = WW'(RPT);
    localparam logic [LW-1:0] LAST_LOW = LW'(TRK_MIN - 1);

    trk_state_e       state_q;
    logic [WW-1:0]    wcnt_q;
    logic [LW-1:0]    low_cnt_q;
    logic [ERR_W-1:0] cap_q;
    logic             good_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state_q   <= TRK_IDLE;
            wcnt_q    <= '0;
            low_cnt_q <= '0;
            cap_q     <= '0;
            good_q    <= 1'b0;
            valid     <= 1'b0;
            missed    <= 1'b0;
            err       <= '0;
        end else begin
            valid  <= 1'b0;
            missed <= 1'b0;
            err    <= '0;
            if (state_q == TRK_IDLE) begin
                if (win_open) begin
                    state_q <= TRK_SEEK;
                    wcnt_q  <= '0;
                    good_q  <= 1'b0;
                end
            end else if (wcnt_q == RPT_C) begin
                // fixed report point: every window ends in one verdict
                valid   <= good_q;
                missed  <= !good_q;
                err     <= good_q ? cap_q : '0;
                state_q <= TRK_IDLE;
            end else begin
                wcnt_q <= wcnt_q + WW'(1);
                case (state_q)
                    TRK_SEEK: begin
                        if (view.fall && (wcnt_q < WIN_END)) begin
                            cap_q     <= line_phase;
                            low_cnt_q <= LW'(1);
                            state_q   <= TRK_MEASURE;
                        end
                    end
                    TRK_MEASURE: begin
                        if (view.level) begin
                            good_q  <= 1'b0;
                            state_q <= TRK_HOLD;
                        end else if (low_cnt_q == LAST_LOW) begin
                            good_q  <= 1'b1;
                            state_q <= TRK_HOLD;
                        end else begin
                            low_cnt_q <= low_cnt_q + LW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_strobe_single_R12: assert property (@(posedge clk) disable iff (rst)
        (valid || missed) |=> !(valid || missed));

    assert_report_point_R8: assert property (@(posedge clk) disable iff (rst)
        (valid || missed) |-> (wcnt_q == RPT_C && state_q == TRK_IDLE));

endmodule

// File: rtl/sq_miss.sv
module sq_miss
    import sync_qual_pkg::*;
#(
    parameter int unsigned MISS_LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic valid,
    input  logic missed,
    output logic resync
);
    localparam int unsigned MW = span_bits(MISS_LIMIT);
    localparam logic [MW-1:0] LAST_MISS = MW'(MISS_LIMIT - 1);

    logic [MW-1:0] miss_cnt_q;

    assign resync = missed && (miss_cnt_q == LAST_MISS);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            miss_cnt_q <= '0;
        end else if (valid) begin
            miss_cnt_q <= '0;
        end else if (missed) begin
            miss_cnt_q <= (miss_cnt_q == LAST_MISS) ? '0 : miss_cnt_q + MW'(1);
        end
    end

    assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
        miss_cnt_q < MW'(MISS_LIMIT));

endmodule

// File: rtl/sync_pulse_qualifier.sv
module sync_pulse_qualifier
    import sync_qual_pkg::*;
#(
    parameter int unsigned ACQ_MIN    = 200,
    parameter int unsigned TRK_MIN    = 100,
    parameter int unsigned HALF_WIN   = 96,
    parameter int unsigned MISS_LIMIT = 32,
    parameter int unsigned ERR_W      = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_n_raw,
    input  logic             track_en,
    input  logic             win_open,
    input  logic [ERR_W-1:0] line_phase,
    output logic             line_restart,
    output logic             pulse_valid,
    output logic             pulse_missed,
    output logic [ERR_W-1:0] phase_err,
    output logic             resync_req
);
    sync_view_t       view;
    logic             acq_valid, trk_valid, trk_missed;
    logic [ERR_W-1:0] acq_err, trk_err;

    sq_sync2 u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_n (sync_n_raw),
        .view  (view)
    );

    sq_acq #(
        .ACQ_MIN (ACQ_MIN),
        .ERR_W   (ERR_W)
    ) u_acq (
        .clk        (clk),
        .rst        (rst),
        .enable     (!track_en),
        .view       (view),
        .line_phase (line_phase),
        .restart    (line_restart),
        .valid      (acq_valid),
        .err        (acq_err)
    );

    sq_track #(
        .TRK_MIN  (TRK_MIN),
        .HALF_WIN (HALF_WIN),
        .ERR_W    (ERR_W)
    ) u_track (
        .clk        (clk),
        .rst        (rst),
        .enable     (track_en),
        .win_open   (win_open),
        .view       (view),
        .line_phase (line_phase),
        .valid      (trk_valid),
        .missed     (trk_missed),
        .err        (trk_err)
    );

    sq_miss #(
        .MISS_LIMIT (MISS_LIMIT)
    ) u_miss (
        .clk    (clk),
        .rst    (rst),
        .enable (track_en),
        .valid  (pulse_valid),
        .missed (trk_missed),
        .resync (resync_req)
    );

    // Engines are mutually reset by mode, so their strobes never overlap
    assign pulse_valid  = acq_valid | trk_valid;
    assign pulse_missed = trk_missed;
    assign phase_err    = acq_err | trk_err;

    assert_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
        !(pulse_valid && pulse_missed));

    assert_missed_err_zero_R9: assert property (@(posedge clk) disable iff (rst)
        pulse_missed |-> (phase_err == '0));

    assert_resync_with_miss_R10: assert property (@(posedge clk) disable iff (rst)
        resync_req |-> pulse_missed);

    assert_mode_gate_R13: assert property (@(posedge clk) disable iff (rst)
        $past(!track_en) |-> !pulse_missed);

    assert_no_restart_tracking_R13: assert property (@(posedge clk) disable iff (rst)
        $past(track_en) |-> !line_restart);

endmodule

// File: tb/test_sync_pulse_qualifier.sv
module test_sync_pulse_qualifier;
    localparam int CLK_PERIOD = 20;
    localparam int ACQ_MIN    = 6;
    localparam int TRK_MIN    = 3;
    localparam int HALF_WIN   = 4;
    localparam int MISS_LIMIT = 4;
    localparam int ERR_W      = 6;
    localparam int WIN_LEN    = 2 * HALF_WIN;
    localparam int VERDICT_N  = WIN_LEN + TRK_MIN + 1; // cycle index of verdict

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             sync_n_raw = 1'b1;
    logic             track_en = 1'b0;
    logic             win_open = 1'b0;
    logic [ERR_W-1:0] line_phase = '0;
    logic             line_restart, pulse_valid, pulse_missed, resync_req;
    logic [ERR_W-1:0] phase_err;

    int checks = 0;
    int errors = 0;
    int miss_model = 0;
    int tbase = 5;

    sync_pulse_qualifier #(
        .ACQ_MIN    (ACQ_MIN),
        .TRK_MIN    (TRK_MIN),
        .HALF_WIN   (HALF_WIN),
        .MISS_LIMIT (MISS_LIMIT),
        .ERR_W      (ERR_W)
    ) i_sync_pulse_qualifier (
        .clk          (clk),
        .rst          (rst),
        .sync_n_raw   (sync_n_raw),
        .track_en     (track_en),
        .win_open     (win_open),
        .line_phase   (line_phase),
        .line_restart (line_restart),
        .pulse_valid  (pulse_valid),
        .pulse_missed (pulse_missed),
        .phase_err    (phase_err),
        .resync_req   (resync_req)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int phase_at(input int n);
        return (tbase + n * 13) & ((1 << ERR_W) - 1);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input int n, input int e_rs, input int e_v,
                             input int e_m, input int e_err, input int e_sync);
        string w;
        w = $sformatf("cycle %0d", n);
        check(tag, {w, " line_restart"}, int'(line_restart), e_rs);
        check(tag, {w, " pulse_valid"}, int'(pulse_valid), e_v);
        check(tag, {w, " pulse_missed"}, int'(pulse_missed), e_m);
        check(tag, {w, " phase_err"}, int'(phase_err), e_err);
        check(tag, {w, " resync_req"}, int'(resync_req), e_sync);
    endtask

    // Tracking window: win_open driven at cycle 0, pulse low from cycle k for len cycles
    task automatic run_track(input string tag, input int k, input int len, input bit extra_open);
        bit good;
        int eerr, last, fire;
        good = (k + 1 >= 0) && (k + 1 <= WIN_LEN - 1) && (len >= TRK_MIN); // R6 R7
        eerr = good ? phase_at(k + 2) : 0;                                  // R9
        fire = (!good && miss_model == MISS_LIMIT - 1) ? 1 : 0;             // R10
        last = VERDICT_N + 4;
        if (len > 0 && k + len + 2 > last) last = k + len + 2;
        for (int n = -6; n <= last; n++) begin
            @(negedge clk);
            if (n == VERDICT_N)
                check_all(tag, n, 0, good ? 1 : 0, good ? 0 : 1, eerr, fire);  // R8
            else
                check_all(tag, n, 0, 0, 0, 0, 0);                              // R12
            sync_n_raw = !(len > 0 && n >= k && n < k + len);
            win_open   = (n == 0) || (extra_open && (n == 3 || n == VERDICT_N - 2)); // R11
            line_phase = ERR_W'(phase_at(n));
        end
        if (good) miss_model = 0;
        else miss_model = (miss_model == MISS_LIMIT - 1) ? 0 : miss_model + 1;
    endtask

    // Acquisition: pulse low from cycle 0 for len cycles
    task automatic run_acq(input string tag, input int len);
        bit good;
        good = (len >= ACQ_MIN);
        for (int n = -6; n <= len + ACQ_MIN + 4; n++) begin
            @(negedge clk);
            check_all(tag, n, (n == 3) ? 1 : 0,                               // R2
                      (good && n == ACQ_MIN + 2) ? 1 : 0, 0,                   // R3 R4 R5
                      (good && n == ACQ_MIN + 2) ? phase_at(2) : 0, 0);
            sync_n_raw = !(n >= 0 && n < len);
            win_open   = 1'b0;
            line_phase = ERR_W'(phase_at(n));
        end
        miss_model = 0;
    endtask

    task automatic idle_cycles(input string tag, input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge clk);
            check_all(tag, i, 0, 0, 0, 0, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1", 0, 0, 0, 0, 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1", 1, 0, 0, 0, 0, 0);
        idle_cycles("R1", 4);

        // R6 R8 R9: edge position sweep across and beyond the window
        track_en = 1'b1;
        idle_cycles("R13", 3);
        for (int k = -4; k <= WIN_LEN + 1; k++) begin
            tbase = tbase + 11;
            run_track("R6", k, TRK_MIN + 1, 1'b0);
        end
        // R7: width sweep at a fixed in-window position, plus long pulse
        for (int len = 1; len <= TRK_MIN + 2; len++) run_track("R7", 3, len, 1'b0);
        run_track("R7", 2, 4 * TRK_MIN, 1'b0);
        // R11: extra window strobes during an open window
        run_track("R11", 4, TRK_MIN, 1'b1);
        run_track("R11", WIN_LEN + 2, TRK_MIN, 1'b1);
        // R10: consecutive misses, clearing by a valid pulse
        run_track("R10", 1, TRK_MIN, 1'b0);
        for (int i = 0; i < MISS_LIMIT; i++) run_track("R10", 0, 0, 1'b0);
        for (int i = 0; i < MISS_LIMIT - 1; i++) run_track("R10", 0, 0, 1'b0);
        run_track("R10", 2, TRK_MIN, 1'b0);
        for (int i = 0; i < MISS_LIMIT; i++) run_track("R10", 0, 0, 1'b0);
        // R13: leaving tracking mode clears the miss count
        for (int i = 0; i < MISS_LIMIT - 1; i++) run_track("R13", 0, 0, 1'b0);
        track_en = 1'b0;
        miss_model = 0;
        idle_cycles("R13", 5);
        track_en = 1'b1;
        idle_cycles("R13", 2);
        run_track("R13", 0, 0, 1'b0);

        // Acquisition mode: R2 R3 R4 R5
        track_en = 1'b0;
        idle_cycles("R13", 6);
        for (int len = 1; len <= ACQ_MIN + 2; len++) begin
            tbase = tbase + 7;
            run_acq(len >= ACQ_MIN ? "R3" : "R4", len);
        end
        run_acq("R5", 5 * ACQ_MIN);
        // R13: win_open has no effect in acquisition mode
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            check_all("R13", n, 0, 0, 0, 0, 0);
            win_open = (n % 5 == 0);
        end
        win_open = 1'b0;
        track_en = 1'b1;
        idle_cycles("R13", 3);
        run_track("R9", 3, TRK_MIN, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule